// File: doc/BRIEF.md
# Two-Level Rotating Priority Bus Arbiter

This block decides which of ten masters may drive a shared bus: nine external requesters with active-low request and grant lines, plus one internal requester with active-high request and grant. A configuration vector puts each master in either a high tier or a low tier. The high tier is served in round-robin order. The low tier as a whole fills one extra slot in that round. Inside that slot, the low-tier members take turns in their own round-robin.

A transaction-start input moves the rotation forward. A granted master pulses it when it begins a transaction, and only then does the position of that master's tier advance. When no master requests, the grant stays parked on the last owner. The arbiter can be switched off through a strap input that is sampled while reset is held. When it is off, every grant stays deasserted so that an arbiter outside the block can take over.

Top module: `tier_arb`

## Requirements
- R1: The masters are numbered 0 to 9. Master 0 is the internal requester (`int_req`/`int_gnt`). Master j+1 uses `ext_req_n[j]`/`ext_gnt_n[j]`. Bit k of `grp_hi` set to 1 puts master k in the high tier; 0 puts it in the low tier.
- R2: The high-tier round is an ordered ring of slots 0 to 10. Slot k < 10 is master k and takes part only if that master is in the high tier and requesting. Slot 10 stands for the whole low tier. After a high-tier master starts a transaction, the search begins at the slot just after it. After a low-tier master starts one, the search begins at slot 0.
- R3: Inside the low-tier slot, the winner is the first requesting low-tier master found in the order that starts just after the last low-tier master that started a transaction, wrapping from 9 to 0.
- R4: With masters 0 to 3 in the high tier, 4 to 9 in the low tier, every master requesting and each grant used for one transaction, the grants go to 0,1,2,3,4,0,1,2,3,5,0,1,2,3,6 and so on.
- R5: A grant driven by a request is first asserted at the second rising edge after the request is seen, or later.
- R6: At most one grant is asserted at any time.
- R7: Between a grant to one master and a grant to a different master, there is at least one cycle with no grant.
- R8: Both rotation positions advance only at a rising edge where `txn_start` is high while a grant is asserted. Masters that are not requesting are skipped.
- R9: When no master is requesting, the grant is held or parked on the last owner. The owner after reset is master 0.
- R10: `arb_en_strap` is sampled while `rst_n` is low. If it was low, every grant stays deasserted until the next reset.
- R11: While `rst_n` is low, all grants are deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous for the grant state |
| ext_req_n | input | 9 | Active-low requests of external masters 1..9 |
| int_req | input | 1 | Request of internal master 0 |
| grp_hi | input | 10 | Tier select per master, 1 = high tier |
| arb_en_strap | input | 1 | Arbiter enable, sampled during reset |
| txn_start | input | 1 | Granted master starts a transaction |
| ext_gnt_n | output | 9 | Active-low grants of external masters 1..9 |
| int_gnt | output | 1 | Grant of internal master 0 |

## Verification
A wrong rotation position does not show at the ports until at least two masters compete. It then shows as a grant to the wrong master at the first handover after the faulty advance, which is two to three cycles after the `txn_start` that caused it. A bad low-tier position shows only when the low-tier slot comes around, so it can appear up to eleven handovers late. For that reason the bench runs long sequences with all masters requesting under several tier splits. A lost tier slot, a handover with no gap, or a double grant shows on the grant lines in the same cycle. All of these are caught because the bench compares every grant against its own model on every cycle.

// File: rtl/tier_arb_pkg.sv
package tier_arb_pkg;

   // next position in a ring of size m
   function automatic int ring_next(input int v, input int m);
      return (v + 1 >= m) ? 0 : v + 1;
   endfunction

endpackage

// File: rtl/tier_arb_capture.sv
module tier_arb_capture #(
   parameter int N = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_raw,
   input  logic         strap,
   output logic [N-1:0] req_q,
   output logic         en_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= req_raw;
   end

   // strap is captured only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= strap;
   end

endmodule

// File: rtl/tier_arb_pick.sv
module tier_arb_pick #(
   parameter int N    = 10,
   parameter int IDXW = 4
) (
   input  logic [N-1:0]    req,
   input  logic [N-1:0]    grp_hi,
   input  logic [IDXW-1:0] hi_ptr,
   input  logic [IDXW-1:0] lo_ptr,
   output logic            any,
   output logic [IDXW-1:0] win
);

   localparam int SLOTS = N + 1;

   logic [N-1:0]    hi_req, lo_req;
   logic            lo_hit;
   logic [IDXW-1:0] lo_win;

   for (genvar i = 0; i < N; i++) begin : g_split
      assign hi_req[i] = req[i] &  grp_hi[i];
      assign lo_req[i] = req[i] & ~grp_hi[i];
   end

   always_comb begin
      lo_hit = 1'b0;
      lo_win = '0;
      for (int k = 0; k < N; k++) begin
         int c;
         c = int'(lo_ptr) + k;
         if (c >= N) c = c - N;
         if (!lo_hit && lo_req[c]) begin
            lo_hit = 1'b1;
            lo_win = IDXW'(c);
         end
      end
   end

   always_comb begin
      any = 1'b0;
      win = '0;
      for (int k = 0; k < SLOTS; k++) begin
         int s;
         s = int'(hi_ptr) + k;
         if (s >= SLOTS) s = s - SLOTS;
         if (!any) begin
            if (s == N) begin
               if (lo_hit) begin
                  any = 1'b1;
                  win = lo_win;
               end
            end else if (hi_req[s]) begin
               any = 1'b1;
               win = IDXW'(s);
            end
         end
      end
   end

endmodule

// File: rtl/tier_arb_ptr.sv
module tier_arb_ptr
   import tier_arb_pkg::*;
#(
   parameter int N    = 10,
   parameter int IDXW = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv,
   input  logic [IDXW-1:0] owner,
   input  logic [N-1:0]    grp_hi,
   output logic [IDXW-1:0] hi_ptr,
   output logic [IDXW-1:0] lo_ptr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_ptr <= '0;
         lo_ptr <= '0;
      end else if (adv) begin
         if (grp_hi[owner]) begin
            // slot after a high master; owner N-1 leads to the low-tier slot
            hi_ptr <= IDXW'(ring_next(int'(owner), N + 1));
         end else begin
            hi_ptr <= '0;
            lo_ptr <= IDXW'(ring_next(int'(owner), N));
         end
      end
   end

endmodule

// File: rtl/tier_arb.sv
module tier_arb #(
   parameter int NUM_EXT = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EXT-1:0] ext_req_n,
   input  logic               int_req,
   input  logic [NUM_EXT:0]   grp_hi,
   input  logic               arb_en_strap,
   input  logic               txn_start,
   output logic [NUM_EXT-1:0] ext_gnt_n,
   output logic               int_gnt
);

   localparam int N    = NUM_EXT + 1;
   localparam int IDXW = $clog2(N + 1);

   if (NUM_EXT < 1 || NUM_EXT > 30) begin : g_bad_cfg
      $error("tier_arb: NUM_EXT must be 1..30");
   end

   logic [N-1:0]    req_q;
   logic            en_q;
   logic            any;
   logic [IDXW-1:0] win, owner, hi_ptr, lo_ptr;
   logic            gnt_on;
   logic            adv;
   logic [N-1:0]    gv;

   tier_arb_capture #(.N(N)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_raw ({~ext_req_n, int_req}),
      .strap   (arb_en_strap),
      .req_q   (req_q),
      .en_q    (en_q)
   );

   tier_arb_pick #(.N(N), .IDXW(IDXW)) u_pick (
      .req    (req_q),
      .grp_hi (grp_hi),
      .hi_ptr (hi_ptr),
      .lo_ptr (lo_ptr),
      .any    (any),
      .win    (win)
   );

   assign adv = en_q & gnt_on & txn_start;

   tier_arb_ptr #(.N(N), .IDXW(IDXW)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (adv),
      .owner  (owner),
      .grp_hi (grp_hi),
      .hi_ptr (hi_ptr),
      .lo_ptr (lo_ptr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_on <= 1'b0;
         owner  <= '0;
      end else if (!en_q) begin
         gnt_on <= 1'b0;
      end else if (!any) begin
         gnt_on <= 1'b1;           // park on last owner
      end else if (gnt_on && win != owner) begin
         gnt_on <= 1'b0;           // idle cycle before handover
      end else if (!gnt_on) begin
         owner  <= win;
         gnt_on <= 1'b1;
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_gnt
      assign gv[i] = gnt_on && (owner == IDXW'(i));
   end

   assign int_gnt   = gv[0];
   assign ext_gnt_n = ~gv[N-1:1];

endmodule

// File: rtl/tier_arb_chk.sv
module tier_arb_chk #(
   parameter int N = 10
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] gv,
   input logic [N-1:0] req_q,
   input logic         en_q
);

   // R6
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gv));

   // R7
   switch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|gv) |=> (gv == '0) || (gv == $past(gv)));

   // R10
   disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> (gv == '0));

   // R9
   park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|gv) && !(|req_q)) |=> (gv == $past(gv)));

   for (genvar i = 0; i < N; i++) begin : g_src
      // R5
      grant_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(gv[i]) && $past(|req_q)) |-> $past(req_q[i]));
   end

endmodule

bind tier_arb tier_arb_chk #(.N(NUM_EXT + 1)) u_tier_arb_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .gv    ({~ext_gnt_n, int_gnt}),
   .req_q (req_q),
   .en_q  (en_q)
);

// File: tb/test_tier_arb.sv
module test_tier_arb;

   localparam int CLK_NS = 10;
   localparam int NE     = 9;
   localparam int N      = NE + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NE-1:0] ext_req_n = '1;
   logic          int_req = 1'b0;
   logic [N-1:0]  grp_hi = '1;
   logic          arb_en_strap = 1'b1;
   logic          txn_start = 1'b0;
   logic [NE-1:0] ext_gnt_n;
   logic          int_gnt;
   logic [N-1:0]  gv;

   int checks = 0;
   int errors = 0;

   always #(CLK_NS / 2) clk = ~clk;

   tier_arb #(.NUM_EXT(NE)) i_tier_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .ext_req_n    (ext_req_n),
      .int_req      (int_req),
      .grp_hi       (grp_hi),
      .arb_en_strap (arb_en_strap),
      .txn_start    (txn_start),
      .ext_gnt_n    (ext_gnt_n),
      .int_gnt      (int_gnt)
   );

   assign gv = {~ext_gnt_n, int_gnt};

   // ---------------- behavioural reference model ----------------
   int           hi_ring[$];   // slot order, N = low-tier token
   int           lo_ring[$];
   bit           m_on, m_en;
   int           m_owner;
   bit [N-1:0]   m_rq;
   int           o_sv, w, lw;
   bit           adv_sv;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_on = 0; m_owner = 0; m_rq = '0; m_en = arb_en_strap;
         hi_ring = {}; lo_ring = {};
         for (int i = 0; i <= N; i++) hi_ring.push_back(i);
         for (int i = 0; i < N; i++)  lo_ring.push_back(i);
      end else begin
         o_sv = m_owner;
         adv_sv = m_en && m_on && txn_start;
         lw = -1; w = -1;
         foreach (lo_ring[k])
            if (lw < 0 && !grp_hi[lo_ring[k]] && m_rq[lo_ring[k]]) lw = lo_ring[k];
         foreach (hi_ring[k])
            if (w < 0) begin
               if (hi_ring[k] == N) begin
                  if (lw >= 0) w = lw;
               end else if (grp_hi[hi_ring[k]] && m_rq[hi_ring[k]]) w = hi_ring[k];
            end
         if (!m_en)                   m_on = 0;
         else if (w < 0)              m_on = 1;
         else if (m_on && w != m_owner) m_on = 0;
         else if (!m_on) begin m_owner = w; m_on = 1; end
         if (adv_sv) begin
            if (grp_hi[o_sv]) begin
               while (hi_ring[$] != o_sv) hi_ring.push_back(hi_ring.pop_front());
            end else begin
               while (hi_ring[$] != N) hi_ring.push_back(hi_ring.pop_front());
               while (lo_ring[$] != o_sv) lo_ring.push_back(lo_ring.pop_front());
            end
         end
         m_rq = {~ext_req_n, int_req};
      end
   end

   function automatic logic [N-1:0] model_gv();
      return m_on ? (N'(1) << m_owner) : '0;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [N-1:0] act,
                      input logic [N-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   // every negedge: compare against the model (R1 R2 R3 R6 R7 R8 R9)
   task automatic tick();
      @(negedge clk);
      if (rst_n) begin
         checks++;
         if (gv !== model_gv()) begin
            errors++;
            if (errors < 20)
               $display("FAIL R1 R2 R3 R6 R7 R8 R9 model: got %b expected %b", gv, model_gv());
         end
      end else begin
         chk(gv === '0, "R11 grants in reset", gv, '0);
      end
   endtask

   task automatic do_reset(input logic [N-1:0] grp, input logic strap);
      @(negedge clk);
      rst_n = 1'b0; grp_hi = grp; arb_en_strap = strap; txn_start = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
   endtask

   int onsets[$];
   int exp_seq[$];
   logic [N-1:0] prev;

   initial begin
      // R11 reset state, R9 park after reset
      do_reset('1, 1'b1);
      tick();
      chk(gv == N'(1), "R9 park on master 0", gv, N'(1));
      // R5 latency: request master 5 (ext line 4)
      ext_req_n[4] = 1'b0;
      tick();
      chk(gv == N'(1), "R5 no grant one edge after request", gv, N'(1));
      tick();
      chk(gv == '0, "R5 R7 gap before handover", gv, '0);
      tick();
      chk(gv == (N'(1) << 5), "R5 grant to master 5", gv, N'(1) << 5);
      // R8 no advance without txn_start
      ext_req_n[4] = 1'b1; int_req = 1'b1; ext_req_n[0] = 1'b0;
      repeat (20) tick();
      chk(gv == N'(1), "R8 held on master 0 without txn_start", gv, N'(1));
      txn_start = 1'b1; tick(); txn_start = 1'b0;
      tick(); tick();
      chk(gv == (N'(1) << 1), "R8 advance after txn_start", gv, N'(1) << 1);

      // R4 stated order
      ext_req_n = '0; int_req = 1'b1;
      do_reset(N'('h00F), 1'b1);
      for (int r = 0; r < 3; r++) begin
         for (int h = 0; h < 4; h++) exp_seq.push_back(h);
         exp_seq.push_back(4 + r);
      end
      prev = '0;
      for (int c = 0; c < 400 && onsets.size() < 15; c++) begin
         tick();
         if (gv != '0 && prev == '0)
            for (int i = 0; i < N; i++) if (gv[i]) onsets.push_back(i);
         prev = gv;
         txn_start = |gv;
      end
      txn_start = 1'b0;
      for (int i = 0; i < 15; i++) begin
         int a;
         a = (i < onsets.size()) ? onsets[i] : -1;
         checks++;
         if (a != exp_seq[i]) begin
            errors++;
            $display("FAIL R4 order step %0d: got %0d expected %0d", i, a, exp_seq[i]);
         end
      end

      // R10 disabled arbiter
      do_reset('1, 1'b0);
      for (int c = 0; c < 30; c++) begin
         tick();
         chk(gv == '0, "R10 disabled no grant", gv, '0);
      end

      // random tier splits and request patterns against the model
      for (int e = 0; e < 8; e++) begin
         ext_req_n = NE'($urandom); int_req = 1'($urandom);
         do_reset(N'($urandom), 1'b1);
         for (int c = 0; c < 2000; c++) begin
            tick();
            for (int i = 0; i < NE; i++)
               if ($urandom % 8 == 0) ext_req_n[i] = ~ext_req_n[i];
            if ($urandom % 8 == 0) int_req = ~int_req;
            txn_start = (gv != '0) && ($urandom % 3 == 0);
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_NS * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule